// File: doc/BRIEF.md
# EEPROM Write-Protection Gate

This block stands between the parallel control pins of a byte-wide EEPROM and its internal page-write engine. Every write strobe from the host must clear five independent guards before it reaches the engine. The supply must be good. A power-up lockout must have expired. The control pins must form a legal write combination. The strobe must be long enough not to be a glitch. The software lock must either be open or be bypassed by a valid unlock sequence.

The pins are taken as synchronous to `clk`. A write cycle runs while chip enable and write enable are both low and output enable is high. The cycle completes on the clock edge where that combination ends. Address and data come from the last clock cycle of the active phase.

The software lock is off after reset. It is armed by three consecutive writes of fixed address/data pairs, which are parameters. Once armed, plain writes are dropped. After the same three-write sequence, a load window opens, and data writes in that window reach the engine. The armed flag survives supply drops and is cleared only by reset.

Top module: `eeprom_wr_guard`

## Requirements
- R1: While `supply_ok` is low, no write reaches `wr_strobe`.
- R2: After reset or after any low cycle of `supply_ok`, writes stay blocked until `supply_ok` has been high for PWR_DELAY consecutive clock edges. The count restarts from zero on every drop.
- R3: A write cycle exists only while `ce_n`=0, `we_n`=0 and `oe_n`=1. A write enable pulse with `ce_n` high, or with `oe_n` low, produces no strobe.
- R4: A write cycle whose active phase lasts fewer than MIN_PULSE clock cycles is discarded. A phase of exactly MIN_PULSE cycles is accepted.
- R5: An accepted write raises `wr_strobe` for exactly one cycle, in the cycle after the clock edge where the active phase ends. `wr_addr`/`wr_data` carry the address and data from the last active cycle. They hold their value while `wr_strobe` is low.
- R6: After reset `prot_on` is 0, `wr_strobe` is 0, and every accepted write is forwarded.
- R7: Three consecutive accepted writes of (CMD_A0,CMD_D0), (CMD_A1,CMD_D1), (CMD_A2,CMD_D2), in that order, set `prot_on` to 1.
- R8: Any accepted write that does not match the next expected command returns the sequence detector to its start. Matching then has to begin again with the first command.
- R9: While `prot_on` is 1 and no load window is open, accepted writes are not forwarded. This includes the command writes themselves.
- R10: Completing the sequence opens a load window of LOAD_WIN cycles. Each write forwarded inside the window restarts the window. A write arriving after the window has lapsed is discarded.
- R11: `prot_on` stays 1 through supply drops and only reset clears it. A supply drop clears a partial command sequence and closes any open load window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Supply above write threshold |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | AW | Byte address |
| din | input | DW | Write data |
| wr_strobe | output | 1 | One-cycle qualified write to the page engine |
| wr_addr | output | AW | Address of the qualified write |
| wr_data | output | DW | Data of the qualified write |
| prot_on | output | 1 | Software protection armed |

## Verification
Every result of a write is due one cycle after the edge on which the active phase ends. `wr_strobe`, `wr_addr`, `wr_data` and `prot_on` all become valid at that point. The bench drives pins on falling edges and releases the strobe pins after the chosen number of active cycles. It then waits exactly one falling edge and samples all outputs there, so the count of registers between the release and the sample is fixed at one. The power-up lockout and the load window are exercised by waiting whole cycle counts measured from the edge where the supply returns or the sequence completes. Each count is chosen well clear of the limit on the side being tested.

// File: rtl/eeprom_wr_guard.sv
module eeprom_wr_guard #(
  parameter int AW = 13,
  parameter int DW = 8,
  parameter int PWR_DELAY = 250000,
  parameter int MIN_PULSE = 2,
  parameter int LOAD_WIN = 7500,
  parameter logic [AW-1:0] CMD_A0 = 13'h0A5A,
  parameter logic [DW-1:0] CMD_D0 = 8'h3C,
  parameter logic [AW-1:0] CMD_A1 = 13'h15A5,
  parameter logic [DW-1:0] CMD_D1 = 8'hC3,
  parameter logic [AW-1:0] CMD_A2 = 13'h0A5A,
  parameter logic [DW-1:0] CMD_D2 = 8'h5E
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          supply_ok,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic          wr_strobe,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          prot_on
);

  localparam int PW = $clog2(PWR_DELAY + 1);
  localparam int GW = $clog2(MIN_PULSE + 1);
  localparam int LW = $clog2(LOAD_WIN + 1);

  typedef enum logic [1:0] {ARM_IDLE, ARM_ONE, ARM_TWO} arm_t;

  logic [GW-1:0] hold_cnt;
  logic [PW-1:0] pwr_cnt;
  logic [LW-1:0] win_cnt;
  logic [AW-1:0] lat_a;
  logic [DW-1:0] lat_d;
  arm_t          step;

  wire active  = !ce_n && !we_n && oe_n;
  wire ended   = (hold_cnt != '0) && !active;
  wire long_ok = hold_cnt == GW'(MIN_PULSE);
  wire powered = supply_ok && (pwr_cnt == PW'(PWR_DELAY));
  wire good    = ended && long_ok && powered;
  wire win_open = win_cnt != '0;
  wire pass    = good && (!prot_on || win_open);

  wire hit0 = (lat_a == CMD_A0) && (lat_d == CMD_D0);
  wire hit1 = (lat_a == CMD_A1) && (lat_d == CMD_D1);
  wire hit2 = (lat_a == CMD_A2) && (lat_d == CMD_D2);
  wire armed_now = good && (step == ARM_TWO) && hit2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_cnt <= '0;
      lat_a    <= '0;
      lat_d    <= '0;
    end else if (active) begin
      if (!long_ok) hold_cnt <= hold_cnt + 1'b1;
      lat_a <= addr;
      lat_d <= din;
    end else begin
      hold_cnt <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             pwr_cnt <= '0;
    else if (!supply_ok)                    pwr_cnt <= '0;
    else if (pwr_cnt != PW'(PWR_DELAY))     pwr_cnt <= pwr_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              step <= ARM_IDLE;
    else if (!supply_ok)     step <= ARM_IDLE;
    else if (good) begin
      case (step)
        ARM_IDLE: step <= hit0 ? ARM_ONE : ARM_IDLE;
        ARM_ONE:  step <= hit1 ? ARM_TWO : ARM_IDLE;
        default:  step <= ARM_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          prot_on <= 1'b0;
    else if (armed_now)  prot_on <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  win_cnt <= '0;
    else if (!supply_ok)         win_cnt <= '0;
    else if (armed_now)          win_cnt <= LW'(LOAD_WIN);
    else if (pass && win_open)   win_cnt <= LW'(LOAD_WIN);
    else if (win_open)           win_cnt <= win_cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_strobe <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
    end else begin
      wr_strobe <= pass;
      if (pass) begin
        wr_addr <= lat_a;
        wr_data <= lat_d;
      end
    end
  end

endmodule

// File: rtl/eeprom_wr_guard_chk.sv
module eeprom_wr_guard_chk #(
  parameter int AW = 13,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          supply_ok,
  input logic          ce_n,
  input logic          oe_n,
  input logic          we_n,
  input logic          wr_strobe,
  input logic [AW-1:0] wr_addr,
  input logic [DW-1:0] wr_data,
  input logic          prot_on
);

  assert_unpowered_blocks_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> !wr_strobe);

  assert_legal_pins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strobe |-> ($past(!ce_n, 2) && $past(!we_n, 2) && $past(oe_n, 2)));

  assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strobe |=> !wr_strobe);

  assert_outputs_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_strobe |-> ($stable(wr_addr) && $stable(wr_data)));

  assert_sticky_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
    prot_on |=> prot_on);

endmodule

bind eeprom_wr_guard eeprom_wr_guard_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .ce_n(ce_n), .oe_n(oe_n),
  .we_n(we_n), .wr_strobe(wr_strobe), .wr_addr(wr_addr), .wr_data(wr_data),
  .prot_on(prot_on)
);

// File: tb/eeprom_wr_guard_test.sv
module eeprom_wr_guard_test;
  localparam int PD = 40;
  localparam int MP = 2;
  localparam int LW = 20;

  logic clk = 0, rst_n = 0, supply_ok = 1;
  logic ce_n = 1, oe_n = 1, we_n = 1;
  logic [12:0] addr = '0;
  logic [7:0]  din = '0;
  logic wr_strobe, prot_on;
  logic [12:0] wr_addr;
  logic [7:0]  wr_data;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  eeprom_wr_guard #(.PWR_DELAY(PD), .MIN_PULSE(MP), .LOAD_WIN(LW)) uut (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .ce_n(ce_n), .oe_n(oe_n),
    .we_n(we_n), .addr(addr), .din(din), .wr_strobe(wr_strobe),
    .wr_addr(wr_addr), .wr_data(wr_data), .prot_on(prot_on));

  // {addr, data, active cycles, oe_n, ce held high, strobe expected}
  localparam logic [27:0] VEC [7] = '{
    {13'h0010, 8'h11, 4'd3, 1'b1, 1'b0, 1'b1},
    {13'h1FFF, 8'hFF, 4'd2, 1'b1, 1'b0, 1'b1},
    {13'h0020, 8'h22, 4'd1, 1'b1, 1'b0, 1'b0},
    {13'h0030, 8'h33, 4'd3, 1'b0, 1'b0, 1'b0},
    {13'h0040, 8'h44, 4'd3, 1'b1, 1'b1, 1'b0},
    {13'h0000, 8'h00, 4'd8, 1'b1, 1'b0, 1'b1},
    {13'h1234, 8'hA5, 4'd4, 1'b1, 1'b0, 1'b1}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [12:0] a, input logic [7:0] d, input int len,
                    input logic oe, input logic ceh, output logic got);
    addr = a; din = d; oe_n = oe; ce_n = ceh; we_n = 0;
    repeat (len) @(negedge clk);
    we_n = 1; ce_n = 1; oe_n = 1;
    @(negedge clk);
    got = wr_strobe;
    @(negedge clk);
  endtask

  task automatic wr_exp(input logic [12:0] a, input logic [7:0] d, input logic exp, input string req);
    logic g;
    wr(a, d, 3, 1'b1, 1'b0, g);
    chk(g == exp, req, g, exp);
    if (exp && g) chk(wr_addr == a && wr_data == d, req, {wr_addr, wr_data}, {a, d});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic g;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(wr_strobe == 0 && prot_on == 0, "R6 reset", {wr_strobe, prot_on}, 0);
    wr_exp(13'h0005, 8'h55, 1'b0, "R2 lockout after reset");
    repeat (PD + 2) @(negedge clk);

    foreach (VEC[i]) begin
      wr(VEC[i][27:15], VEC[i][14:7], int'(VEC[i][6:3]), VEC[i][2], VEC[i][1], g);
      chk(g == VEC[i][0], "R3/R4/R6 vector", g, VEC[i][0]);
      if (g && VEC[i][0])
        chk(wr_addr == VEC[i][27:15] && wr_data == VEC[i][14:7], "R5 vector data",
            {wr_addr, wr_data}, VEC[i][27:7]);
    end

    supply_ok = 0;
    wr_exp(13'h0100, 8'h01, 1'b0, "R1 supply low");
    supply_ok = 1;
    wr_exp(13'h0101, 8'h02, 1'b0, "R2 lockout restart");
    repeat (PD + 2) @(negedge clk);
    wr_exp(13'h0102, 8'h03, 1'b1, "R2 after delay");

    wr_exp(13'h0A5A, 8'h3C, 1'b1, "R8 cmd0");
    wr_exp(13'h15A5, 8'hC3, 1'b1, "R8 cmd1");
    wr_exp(13'h0777, 8'h77, 1'b1, "R8 mismatch");
    wr_exp(13'h0A5A, 8'h5E, 1'b1, "R8 cmd2 late");
    chk(prot_on == 0, "R8 not armed", prot_on, 0);

    wr_exp(13'h0A5A, 8'h3C, 1'b1, "R7 cmd0");
    wr_exp(13'h15A5, 8'hC3, 1'b1, "R7 cmd1");
    wr_exp(13'h0A5A, 8'h5E, 1'b1, "R7 cmd2");
    chk(prot_on == 1, "R7 armed", prot_on, 1);
    repeat (LW + 10) @(negedge clk);

    wr_exp(13'h0200, 8'h9A, 1'b0, "R9 plain write dropped");
    wr_exp(13'h0A5A, 8'h3C, 1'b0, "R9 cmd0 hidden");
    wr_exp(13'h15A5, 8'hC3, 1'b0, "R9 cmd1 hidden");
    wr_exp(13'h0A5A, 8'h5E, 1'b0, "R9 cmd2 hidden");
    wr_exp(13'h0300, 8'hB1, 1'b1, "R10 window write 1");
    wr_exp(13'h0301, 8'hB2, 1'b1, "R10 window write 2");
    repeat (LW + 10) @(negedge clk);
    wr_exp(13'h0302, 8'hB3, 1'b0, "R10 window lapsed");

    wr_exp(13'h0A5A, 8'h3C, 1'b0, "R11 cmd0");
    wr_exp(13'h15A5, 8'hC3, 1'b0, "R11 cmd1");
    supply_ok = 0;
    repeat (3) @(negedge clk);
    chk(prot_on == 1, "R11 kept in drop", prot_on, 1);
    supply_ok = 1;
    repeat (PD + 2) @(negedge clk);
    wr_exp(13'h0A5A, 8'h5E, 1'b0, "R11 cmd2 after drop");
    wr_exp(13'h0400, 8'hC4, 1'b0, "R11 no window after drop");
    chk(prot_on == 1, "R11 still armed", prot_on, 1);

    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(prot_on == 0 && wr_strobe == 0, "R6 R11 reset clears", {prot_on, wr_strobe}, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule